// File: doc/BRIEF.md
# Embedded-Clock Serial Framer

The framer sits on the transmit side of a point-to-point serial link and runs entirely in the bit-clock domain. Once per frame it samples a 10-bit parallel word and shifts it out on one serial line, one bit per clock. Two clock bits travel with every word: a 1 in front of the data and a 0 behind it. Every frame is therefore 12 bits long, and the receiver finds a guaranteed rising edge at each frame boundary.

A receiver that has not yet locked needs an alignment pattern instead of data. Two sync request lines are provided for this. If either one is high at a frame boundary, the framer sends six 1s followed by six 0s in place of the word. A receiver's lock-status output can be wired straight to one of the request lines. The framer then keeps sending alignment frames back to back until that line drops.

A pulse on the word-load strobe marks the cycle in which the next frame's contents are taken. In that cycle the word and the sync decision are captured, and the new frame starts on the following clock.

The controller is a state machine with these states:
- ST_IDLE: the state after reset. The output is low.
- ST_START: the leading 1.
- ST_DATA: ten cycles, sent LSB first.
- ST_STOP: the trailing 0.
- ST_SYNC_HI: six 1s.
- ST_SYNC_LO: six 0s.

It moves between them as follows:
- The strobe is high in ST_IDLE, in ST_STOP, and in the last cycle of ST_SYNC_LO. From each of these the machine moves to ST_SYNC_HI if a sync request is present, and to ST_START otherwise.
- ST_START always moves to ST_DATA.
- ST_DATA moves to ST_STOP after its tenth bit.
- ST_SYNC_HI moves to ST_SYNC_LO after six cycles.

Top module: `emb_clk_framer`

## Requirements
- R1: While the synchronous reset is high, the serial output is 0 and the load strobe is 0. In the first cycle after reset is released, the load strobe is 1 and the serial output is still 0.
- R2: Once running, the load strobe is high for exactly one cycle in every 12. The serial output is 0 in every strobe cycle and 1 in the cycle that follows it.
- R3: A data frame has 12 bits sent in the 12 cycles after the strobe cycle. They are a 1, then data bits 0 through 9 in that order (LSB first), then a 0.
- R4: A sync frame is 12 bits: 1,1,1,1,1,1,0,0,0,0,0,0. It is sent in place of data when a sync request is high in the strobe cycle.
- R5: Either request line alone, or both together, produces the same sync frame.
- R6: A request held high without a break produces sync frames back to back, with no data frame between them.
- R7: A request that rises or falls in the middle of a frame does not change that frame. It takes effect from the next strobe on.
- R8: The word is sampled only in the strobe cycle. Changes to it at any other time do not alter the frame being sent.
- R9: A reset asserted mid-frame abandons the frame, forces the output low, and leads to a clean frame once it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 10 | Parallel data word, sampled in the strobe cycle |
| sync_a | input | 1 | First sync request, active high |
| sync_b | input | 1 | Second sync request, active high |
| sdo | output | 1 | Serial output bit |
| load_stb | output | 1 | High in the cycle in which the next frame's word and sync decision are captured |

## Verification
The bench checks bit order with asymmetric words such as 0x2A5 and 0x001. A design that sends MSB first, or swaps the start and stop bits, gives a mirrored or shifted frame. Sync requests are raised and dropped in the middle of a frame, and the word is changed in the middle of a frame, to catch a design that samples all the time instead of only at the boundary. Such a design would emit a frame that mixes data and sync bits. Each request line is driven on its own and then held across several frames, which exposes a wrong gating of the two lines or a stray data frame between sync frames. A reset in the middle of a frame checks that the output drops at once and that the first strobe comes right after release; a counter that is not cleared would send a truncated frame.

// File: rtl/framer_pkg.sv
package framer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_START   = 3'd1,
        ST_DATA    = 3'd2,
        ST_STOP    = 3'd3,
        ST_SYNC_HI = 3'd4,
        ST_SYNC_LO = 3'd5
    } fr_state_t;

endpackage

// File: rtl/frame_ctrl.sv
module frame_ctrl
    import framer_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int CW     = $clog2(DATA_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sync_req,
    output fr_state_t     state,
    output logic [CW-1:0] cnt,
    output logic          boundary
);

    localparam int            FRAME_LEN = DATA_W + 2;
    localparam int            HALF_LEN  = FRAME_LEN / 2;
    localparam logic [CW-1:0] DATA_LAST = CW'(DATA_W - 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(HALF_LEN - 1);

    fr_state_t     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          bnd;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next-state and boundary decode
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        bnd   = 1'b0;
        unique case (st_q)
            ST_IDLE:    bnd = 1'b1;
            ST_START: begin
                st_d  = ST_DATA;
                cnt_d = '0;
            end
            ST_DATA: begin
                if (cnt_q == DATA_LAST) begin
                    st_d  = ST_STOP;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_STOP:    bnd = 1'b1;
            ST_SYNC_HI: begin
                if (cnt_q == HALF_LAST) begin
                    st_d  = ST_SYNC_LO;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_SYNC_LO: begin
                if (cnt_q == HALF_LAST) begin
                    bnd = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
        if (bnd) begin
            st_d  = sync_req ? ST_SYNC_HI : ST_START;
            cnt_d = '0;
        end
    end

    assign state    = st_q;
    assign cnt      = cnt_q;
    assign boundary = bnd;

endmodule

// File: rtl/word_latch.sv
module word_latch #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (load) begin
            word <= din;
        end
    end

endmodule

// File: rtl/bit_mux.sv
module bit_mux
    import framer_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int CW     = $clog2(DATA_W)
) (
    input  fr_state_t         state,
    input  logic [CW-1:0]     cnt,
    input  logic [DATA_W-1:0] word,
    output logic              bit_out
);

    // output decode
    always_comb begin
        bit_out = 1'b0;
        unique case (state)
            ST_IDLE:    bit_out = 1'b0;
            ST_START:   bit_out = 1'b1;
            ST_DATA:    bit_out = word[cnt];
            ST_STOP:    bit_out = 1'b0;
            ST_SYNC_HI: bit_out = 1'b1;
            ST_SYNC_LO: bit_out = 1'b0;
            default:    bit_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/emb_clk_framer.sv
module emb_clk_framer
    import framer_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic              sync_a,
    input  logic              sync_b,
    output logic              sdo,
    output logic              load_stb
);

    localparam int CW = $clog2(DATA_W);

    fr_state_t         state;
    logic [CW-1:0]     cnt;
    logic              boundary;
    logic              load;
    logic [DATA_W-1:0] word;

    assign load     = boundary & ~rst;
    assign load_stb = load;

    frame_ctrl #(.DATA_W(DATA_W), .CW(CW)) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .sync_req (sync_a | sync_b),
        .state    (state),
        .cnt      (cnt),
        .boundary (boundary)
    );

    word_latch #(.DATA_W(DATA_W)) latch_i (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .din  (din),
        .word (word)
    );

    bit_mux #(.DATA_W(DATA_W), .CW(CW)) mux_i (
        .state   (state),
        .cnt     (cnt),
        .word    (word),
        .bit_out (sdo)
    );

endmodule

// File: rtl/framer_chk.sv
module framer_chk #(
    parameter int DATA_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] din,
    input logic              sync_a,
    input logic              sync_b,
    input logic              sdo,
    input logic              load_stb
);

    localparam int FRAME_LEN = DATA_W + 2;
    localparam int GW        = $clog2(FRAME_LEN + 1);

    logic [GW-1:0] gap;
    logic          seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (load_stb) begin
            gap  <= '0;
            seen <= 1'b1;
        end else begin
            gap <= gap + 1'b1;
        end
    end

    // R1
    reset_low_chk: assert property (@(posedge clk) rst |=> !sdo);

    // R2
    frame_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (load_stb && seen) |-> (gap == GW'(FRAME_LEN - 1)));

    // R2
    strobe_low_chk: assert property (@(posedge clk) disable iff (rst)
        load_stb |-> !sdo);

    // R3
    data_lead_chk: assert property (@(posedge clk) disable iff (rst)
        (load_stb && !(sync_a || sync_b)) |=> sdo ##1 (sdo == $past(din[0], 2)));

    // R4
    sync_lead_chk: assert property (@(posedge clk) disable iff (rst)
        (load_stb && (sync_a || sync_b)) |=> sdo ##1 sdo);

endmodule

bind emb_clk_framer framer_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .din      (din),
    .sync_a   (sync_a),
    .sync_b   (sync_b),
    .sdo      (sdo),
    .load_stb (load_stb)
);

// File: tb/emb_clk_framer_tb.sv
`timescale 1ns/1ps
module emb_clk_framer_tb_top;

    localparam int DW = 10;
    localparam int FL = DW + 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] din = '0;
    logic          sync_a = 1'b0;
    logic          sync_b = 1'b0;
    logic          sdo;
    logic          load_stb;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    emb_clk_framer #(.DATA_W(DW)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .sync_a   (sync_a),
        .sync_b   (sync_b),
        .sdo      (sdo),
        .load_stb (load_stb)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [FL-1:0] data_frame(input logic [DW-1:0] d);
        logic [FL-1:0] f;
        f[0] = 1'b1;
        for (int i = 0; i < DW; i++) f[i+1] = d[i];
        f[FL-1] = 1'b0;
        return f;
    endfunction

    function automatic logic [FL-1:0] sync_frame();
        logic [FL-1:0] f;
        for (int i = 0; i < FL; i++) f[i] = (i < FL/2);
        return f;
    endfunction

    // Wait at a negedge for the strobe, apply inputs, collect 12 bits.
    // Optional mid-frame changes at bit position mid_at.
    task automatic run_frame(input string req, input logic [DW-1:0] d,
                             input logic sa, input logic sb,
                             input int mid_at, input logic [DW-1:0] d_mid,
                             input logic sa_mid, input logic [FL-1:0] exp);
        logic [FL-1:0] got;
        int            stb_hits;
        while (!load_stb) @(negedge clk);
        din = d; sync_a = sa; sync_b = sb;
        stb_hits = 0;
        for (int i = 0; i < FL; i++) begin
            @(negedge clk);
            got[i] = sdo;
            if (load_stb) stb_hits++;
            if (i == mid_at) begin
                din = d_mid;
                sync_a = sa_mid;
            end
        end
        chk(req, 32'(got), 32'(exp));
        chk("R2 strobe once per frame", 32'(stb_hits), 32'd1);
        chk("R2 strobe at frame end", 32'(load_stb), 32'd1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 sdo in reset", 32'(sdo), 32'd0);
        chk("R1 strobe in reset", 32'(load_stb), 32'd0);
        rst = 1'b0;
        #1;
        chk("R1 strobe after release", 32'(load_stb), 32'd1);
        chk("R1 sdo after release", 32'(sdo), 32'd0);
    endtask

    task automatic t_data();
        run_frame("R3 data 2A5", 10'h2A5, 0, 0, -1, '0, 0, data_frame(10'h2A5));
        run_frame("R3 data 000", 10'h000, 0, 0, -1, '0, 0, data_frame(10'h000));
        run_frame("R3 data 3FF", 10'h3FF, 0, 0, -1, '0, 0, data_frame(10'h3FF));
        run_frame("R3 data 001", 10'h001, 0, 0, -1, '0, 0, data_frame(10'h001));
    endtask

    task automatic t_sync_lines();
        run_frame("R4 R5 sync_a", 10'h155, 1, 0, -1, '0, 1, sync_frame());
        run_frame("R3 data between", 10'h0F0, 0, 0, -1, '0, 0, data_frame(10'h0F0));
        run_frame("R4 R5 sync_b", 10'h155, 0, 1, -1, '0, 0, sync_frame());
        run_frame("R4 R5 both", 10'h155, 1, 1, -1, '0, 1, sync_frame());
    endtask

    task automatic t_sync_held();
        for (int k = 0; k < 3; k++)
            run_frame("R6 held sync", 10'h2AA, 1, 0, -1, '0, 1, sync_frame());
        run_frame("R6 release", 10'h2AA, 0, 0, -1, '0, 0, data_frame(10'h2AA));
    endtask

    task automatic t_mid_changes();
        // R7: sync rises mid-frame, frame stays data, next one is sync
        run_frame("R7 rise mid", 10'h1C3, 0, 0, 4, 10'h1C3, 1, data_frame(10'h1C3));
        // R7: sync falls mid-frame, frame stays sync
        run_frame("R7 fall mid", 10'h1C3, 1, 0, 3, 10'h1C3, 0, sync_frame());
        // R8: word changes mid-frame, frame keeps sampled word
        run_frame("R8 din mid", 10'h0A5, 0, 0, 2, 10'h35A, 0, data_frame(10'h0A5));
        run_frame("R8 new word next", 10'h35A, 0, 0, -1, '0, 0, data_frame(10'h35A));
    endtask

    task automatic t_mid_reset();
        while (!load_stb) @(negedge clk);
        din = 10'h3FF; sync_a = 0; sync_b = 0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 sdo after mid reset", 32'(sdo), 32'd0);
        chk("R9 strobe in mid reset", 32'(load_stb), 32'd0);
        rst = 1'b0;
        #1;
        chk("R9 strobe after release", 32'(load_stb), 32'd1);
        run_frame("R9 clean frame", 10'h211, 0, 0, -1, '0, 0, data_frame(10'h211));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_data();
        t_sync_lines();
        t_sync_held();
        t_mid_changes();
        t_mid_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule